// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is the device side of a serial memory reached over three wires: a chip select, a serial clock and a data input, plus one data output with its own output enable. Each time chip select goes high, the block waits for a start bit. It then collects a two-bit operation code and an address field, and for the two data-carrying commands it also collects a data word. Once the frame is complete, it carries out the command on an internal array of storage words.

The storage is organised either as bytes or as 16-bit words, chosen by a parameter. The address field is one bit narrower in word organisation. Programming commands are blocked until software sends an explicit enable. After every accepted programming command, data out reports busy for a fixed number of serial clocks once chip select drops, and then reports ready. This lets the host poll for completion.

Top module: `tri_wire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, every storage word is zero, data out shows ready (1) and do_oe_o is low while cs_i is low.
- R2: A frame begins only with the first 1 on di_i sampled at a rising sck_i edge after cs_i has been low. Zeros that arrive before that 1 are ignored.
- R3: READ is operation code 10. On the rising edge that takes in the last address bit, data out drives a 0 for one clock. On the following edges it shifts the addressed word out, most significant bit first.
- R4: WRITE is operation code 01. The address is followed by a data word of 8 bits (byte organisation) or 16 bits (word organisation), most significant bit first, and the word is stored at the address.
- R5: No programming command (write, erase, erase-all, write-all) changes storage or starts a busy period unless an enable was received earlier. A disable command blocks programming again.
- R6: ERASE is operation code 11. It sets the addressed word to all ones.
- R7: Erase-all sets every storage word to all ones.
- R8: Write-all takes a data word like WRITE and loads it into every storage word.
- R9: At the first rising edge with cs_i low after an accepted programming command, a busy period of BUSY_CLKS edges starts. Data out is 0 during it and 1 once it ends. do_oe_o follows cs_i.
- R10: A start bit that arrives during a busy period is discarded together with the rest of its frame.
- R11: Operation code 00 picks a special command from the two most significant address bits: 11 enable, 10 erase-all, 01 write-all, 00 disable. The remaining address bits must be clocked in but have no effect.
- R12: After a frame completes, further bits are ignored until cs_i has gone low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck_i | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high; low ends a frame |
| di_i | input | 1 | Serial data in, sampled on rising sck_i |
| do_o | output | 1 | Serial data out: read data, or ready (1) / busy (0) |
| do_oe_o | output | 1 | Output enable for do_o, high while cs_i is high |

## Verification
Every address is written with an arithmetic pattern. Each frame is preceded by a varying number of leading zeros, so that start detection and address/data alignment are both exercised. A full read-back sweep then separates correct decoding from off-by-one shifting. Erase on a subset of addresses, write-all, erase-all, and a disable followed by programming attempts each leave a different storage picture, so reading the whole array tells apart which command actually ran. The special commands are sent with non-zero filler bits, a start bit is placed inside a busy window, and extra bits follow a finished frame. The length of the busy window is counted after every frame.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      FS_WAIT,
      FS_HDR,
      FS_DATA,
      FS_READ,
      FS_DONE
   } fr_state_e;

   typedef enum logic [2:0] {
      CMD_READ,
      CMD_WRITE,
      CMD_ERASE,
      CMD_ERAL,
      CMD_WRAL,
      CMD_EWEN,
      CMD_EWDS,
      CMD_NONE
   } cmd_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_LOCK   = 2'b00;
   localparam logic [1:0] EX_FILL   = 2'b01;
   localparam logic [1:0] EX_CLRALL = 2'b10;
   localparam logic [1:0] EX_UNLOCK = 2'b11;

   function automatic logic is_prog(input cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
   endfunction

   function automatic logic takes_data(input cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_WRAL);
   endfunction

   function automatic cmd_e decode_hdr(input logic [1:0] op, input logic [1:0] ext);
      cmd_e c;
      case (op)
         OP_READ:  c = CMD_READ;
         OP_WRITE: c = CMD_WRITE;
         OP_ERASE: c = CMD_ERASE;
         default: begin
            case (ext)
               EX_UNLOCK: c = CMD_EWEN;
               EX_CLRALL: c = CMD_ERAL;
               EX_FILL:   c = CMD_WRAL;
               default:   c = CMD_EWDS;
            endcase
         end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/eep_framer.sv
module eep_framer
   import eep_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_i,
   input  logic          di_i,
   input  logic          busy_i,
   input  logic [DW-1:0] rdata_i,
   output logic          cmd_vld_o,
   output cmd_e          cmd_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          rd_active_o,
   output logic          rd_bit_o
);

   localparam int HW      = AW + 2;
   localparam int CNT_MAX = (HW > DW) ? HW : DW;
   localparam int CW      = $clog2(CNT_MAX + 1);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("eep_framer: AW must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("eep_framer: DW must be at least 2");
      end
   endgenerate

   fr_state_e     st_q;
   logic [HW-1:0] hdr_q;
   logic [DW-1:0] dsr_q;
   logic [DW-1:0] rsr_q;
   logic [CW-1:0] cnt_q;
   logic          rd_bit_q;

   logic [HW-1:0] hdr_full;
   logic [DW-1:0] dat_full;
   logic          hdr_last;
   logic          dat_last;
   cmd_e          hdr_cmd;
   cmd_e          dat_cmd;

   always_comb begin
      hdr_full = {hdr_q[HW-2:0], di_i};
      dat_full = {dsr_q[DW-2:0], di_i};
      hdr_last = (st_q == FS_HDR)  && (cnt_q == CW'(HW - 1));
      dat_last = (st_q == FS_DATA) && (cnt_q == CW'(DW - 1));
      hdr_cmd  = decode_hdr(hdr_full[HW-1 -: 2], hdr_full[AW-1 -: 2]);
      dat_cmd  = (hdr_q[HW-1 -: 2] == OP_WRITE) ? CMD_WRITE : CMD_WRAL;
   end

   always_comb begin
      cmd_vld_o = 1'b0;
      cmd_o     = CMD_NONE;
      if (cs_i && hdr_last && !takes_data(hdr_cmd)) begin
         cmd_vld_o = 1'b1;
         cmd_o     = hdr_cmd;
      end else if (cs_i && dat_last) begin
         cmd_vld_o = 1'b1;
         cmd_o     = dat_cmd;
      end
   end

   assign addr_o      = hdr_last ? hdr_full[AW-1:0] : hdr_q[AW-1:0];
   assign wdata_o     = dat_full;
   assign rd_active_o = (st_q == FS_READ);
   assign rd_bit_o    = rd_bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= FS_WAIT;
         hdr_q    <= '0;
         dsr_q    <= '0;
         rsr_q    <= '0;
         cnt_q    <= '0;
         rd_bit_q <= 1'b0;
      end else if (!cs_i) begin
         st_q  <= FS_WAIT;
         cnt_q <= '0;
      end else begin
         case (st_q)
            FS_WAIT: begin
               if (di_i) begin
                  st_q  <= busy_i ? FS_DONE : FS_HDR;
                  cnt_q <= '0;
               end
            end
            FS_HDR: begin
               hdr_q <= hdr_full;
               cnt_q <= cnt_q + 1'b1;
               if (hdr_last) begin
                  cnt_q <= '0;
                  if (hdr_cmd == CMD_READ) begin
                     st_q     <= FS_READ;
                     rd_bit_q <= 1'b0;
                     rsr_q    <= rdata_i;
                  end else if (takes_data(hdr_cmd)) begin
                     st_q <= FS_DATA;
                  end else begin
                     st_q <= FS_DONE;
                  end
               end
            end
            FS_DATA: begin
               dsr_q <= dat_full;
               cnt_q <= cnt_q + 1'b1;
               if (dat_last) begin
                  st_q <= FS_DONE;
               end
            end
            FS_READ: begin
               rd_bit_q <= rsr_q[DW-1];
               rsr_q    <= {rsr_q[DW-2:0], 1'b0};
            end
            default: begin
               st_q <= FS_DONE;
            end
         endcase
      end
   end

   // R3: the first clock of a read always carries the dummy zero
   assert_read_dummy_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_READ && $past(st_q) == FS_HDR) |-> !rd_bit_q);

   // R12: a finished frame stays finished while chip select is held
   assert_done_sticky_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_DONE && cs_i) |=> (st_q == FS_DONE || $past(!cs_i)));

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
   import eep_pkg::*;
#(
   parameter int BUSY_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic cmd_vld_i,
   input  cmd_e cmd_i,
   output logic wel_o,
   output logic busy_o,
   output logic prog_o
);

   localparam int BW = $clog2(BUSY_CLKS + 1);

   generate
      if (BUSY_CLKS < 1) begin : g_bad_busy
         $error("eep_ctrl: BUSY_CLKS must be at least 1");
      end
   endgenerate

   logic          wel_q;
   logic          pend_q;
   logic [BW-1:0] bcnt_q;

   assign prog_o = cmd_vld_i && wel_q && is_prog(cmd_i);
   assign wel_o  = wel_q;
   assign busy_o = (bcnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (cmd_vld_i && cmd_i == CMD_EWEN) begin
         wel_q <= 1'b1;
      end else if (cmd_vld_i && cmd_i == CMD_EWDS) begin
         wel_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         bcnt_q <= '0;
      end else begin
         if (prog_o) begin
            pend_q <= 1'b1;
         end else if (!cs_i && pend_q) begin
            pend_q <= 1'b0;
         end
         if (!cs_i && pend_q) begin
            bcnt_q <= BW'(BUSY_CLKS);
         end else if (bcnt_q != '0) begin
            bcnt_q <= bcnt_q - BW'(1);
         end
      end
   end

   // R9: the busy window counts down one step per clock
   assert_busy_countdown_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (bcnt_q != '0) |=> (bcnt_q == $past(bcnt_q) - BW'(1)));

   // R9: busy only starts at an edge that saw chip select low
   assert_busy_after_drop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(!cs_i));

   // R5: the enable latch moves only on an enable or disable command
   assert_wel_by_cmd_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wel_q != $past(wel_q)) |-> $past(cmd_vld_i && (cmd_i == CMD_EWEN || cmd_i == CMD_EWDS)));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_one_i,
   input  logic          we_all_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (we_all_i || (we_one_i && waddr_i == AW'(i))) begin
               mem_q[i] <= wdata_i;
            end
         end
      end
   end

   assign rdata_o = mem_q[raddr_i];

   // R7/R8: a bulk write and a single write never fire together
   assert_one_write_kind_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(we_one_i && we_all_i));

endmodule

// File: rtl/tri_wire_eeprom.sv
module tri_wire_eeprom
   import eep_pkg::*;
#(
   parameter bit ORG16     = 1'b1,
   parameter int ADDR_W8   = 7,
   parameter int BUSY_CLKS = 4
) (
   input  logic sck_i,
   input  logic rst_n_i,
   input  logic cs_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);

   localparam int AW = ORG16 ? (ADDR_W8 - 1) : ADDR_W8;
   localparam int DW = ORG16 ? 16 : 8;

   generate
      if (ADDR_W8 < 3) begin : g_bad_addr
         $error("tri_wire_eeprom: ADDR_W8 must be at least 3");
      end
      if (ADDR_W8 > 12) begin : g_big_addr
         $error("tri_wire_eeprom: ADDR_W8 above 12 makes the array too large");
      end
   endgenerate

   logic          cmd_vld;
   cmd_e          cmd;
   logic [AW-1:0] addr;
   logic [DW-1:0] fr_wdata;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] rdata;
   logic          rd_active;
   logic          rd_bit;
   logic          wel;
   logic          busy;
   logic          prog;
   logic          we_one;
   logic          we_all;

   eep_framer #(.AW(AW), .DW(DW)) u_framer (
      .clk         (sck_i),
      .rst_n       (rst_n_i),
      .cs_i        (cs_i),
      .di_i        (di_i),
      .busy_i      (busy),
      .rdata_i     (rdata),
      .cmd_vld_o   (cmd_vld),
      .cmd_o       (cmd),
      .addr_o      (addr),
      .wdata_o     (fr_wdata),
      .rd_active_o (rd_active),
      .rd_bit_o    (rd_bit)
   );

   eep_ctrl #(.BUSY_CLKS(BUSY_CLKS)) u_ctrl (
      .clk       (sck_i),
      .rst_n     (rst_n_i),
      .cs_i      (cs_i),
      .cmd_vld_i (cmd_vld),
      .cmd_i     (cmd),
      .wel_o     (wel),
      .busy_o    (busy),
      .prog_o    (prog)
   );

   always_comb begin
      we_one    = prog && (cmd == CMD_WRITE || cmd == CMD_ERASE);
      we_all    = prog && (cmd == CMD_ERAL  || cmd == CMD_WRAL);
      mem_wdata = (cmd == CMD_ERASE || cmd == CMD_ERAL) ? {DW{1'b1}} : fr_wdata;
   end

   eep_array #(.AW(AW), .DW(DW)) u_array (
      .clk      (sck_i),
      .rst_n    (rst_n_i),
      .we_one_i (we_one),
      .we_all_i (we_all),
      .waddr_i  (addr),
      .wdata_i  (mem_wdata),
      .raddr_i  (addr),
      .rdata_o  (rdata)
   );

   assign do_o    = rd_active ? rd_bit : ~busy;
   assign do_oe_o = cs_i;

   // R10: the framer never completes a command inside a busy window
   assert_no_cmd_while_busy_R10 : assert property (@(posedge sck_i) disable iff (!rst_n_i)
      busy |-> !cmd_vld);

   // R5: storage writes only happen with the enable latch set
   assert_write_needs_wel_R5 : assert property (@(posedge sck_i) disable iff (!rst_n_i)
      (we_one || we_all) |-> wel);

endmodule

// File: tb/tri_wire_eeprom_tb.sv
module tri_wire_eeprom_tb;

   localparam int AW    = 6;
   localparam int DW    = 16;
   localparam int B     = 4;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic di = 1'b0;
   logic dout;
   logic doe;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] model [DEPTH];

   always #5 clk = ~clk;

   tri_wire_eeprom #(.ORG16(1'b1), .ADDR_W8(AW + 1), .BUSY_CLKS(B)) u_dut (
      .sck_i   (clk),
      .rst_n_i (rst_n),
      .cs_i    (cs),
      .di_i    (di),
      .do_o    (dout),
      .do_oe_o (doe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic sbit(input logic b);
      @(negedge clk);
      cs = 1'b1;
      di = b;
   endtask

   task automatic sbits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(v[i]);
   endtask

   task automatic finish_cs(input bit prog, input string req);
      int n;
      @(negedge clk);
      cs = 1'b0;
      di = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!dout && n < 40);
      check(n == (prog ? B + 1 : 1), req, n, prog ? B + 1 : 1);
   endtask

   task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                           input bit has_data, input logic [DW-1:0] d, input int lz);
      for (int i = 0; i < lz; i++) sbit(1'b0);
      sbit(1'b1);
      sbits(32'(op), 2);
      sbits(32'(a), AW);
      if (has_data) sbits(32'(d), DW);
   endtask

   task automatic rd(input logic [AW-1:0] a, input int lz, output logic [DW-1:0] q);
      send_cmd(2'b10, a, 1'b0, '0, lz);
      @(negedge clk);
      check(dout == 1'b0, "R3 dummy zero", dout, 0);
      check(doe == 1'b1, "R9 oe high with cs", doe, 1);
      q = '0;
      for (int i = 0; i < DW; i++) begin
         @(negedge clk);
         q = {q[DW-2:0], dout};
      end
      finish_cs(1'b0, "R3 read leaves ready");
   endtask

   task automatic read_all(input string req);
      logic [DW-1:0] q;
      for (int a = 0; a < DEPTH; a++) begin
         rd(AW'(a), (a + 1) % 3, q);
         check(q == model[a], req, q, model[a]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] q;
      for (int a = 0; a < DEPTH; a++) model[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(doe == 1'b0, "R1 oe low", doe, 0);
      check(dout == 1'b1, "R1 ready", dout, 1);

      // R5/R1: write with the latch clear does nothing
      send_cmd(2'b01, 6'd3, 1'b1, 16'h1234, 0);
      finish_cs(1'b0, "R5 locked write no busy");
      rd(6'd3, 1, q);
      check(q == 16'h0000, "R1 R5 locked write", q, 0);

      // R11: enable with non-zero filler bits
      send_cmd(2'b00, {2'b11, 4'b1010}, 1'b0, '0, 2);
      finish_cs(1'b0, "R11 enable no busy");

      // R4/R2/R9: write every address with leading zeros
      for (int a = 0; a < DEPTH; a++) begin
         model[a] = 16'(a * 16'h0371) ^ 16'hA5C3;
         send_cmd(2'b01, AW'(a), 1'b1, model[a], a % 4);
         finish_cs(1'b1, "R9 busy length after write");
      end
      read_all("R4 R2 write sweep");

      // R6: erase a subset
      for (int a = 0; a < DEPTH; a += 5) begin
         model[a] = '1;
         send_cmd(2'b11, AW'(a), 1'b0, '0, a % 2);
         finish_cs(1'b1, "R6 erase busy");
      end
      read_all("R6 erase sweep");

      // R10: start during busy is discarded
      model[10] = 16'hBEEF;
      send_cmd(2'b01, 6'd10, 1'b1, 16'hBEEF, 0);
      @(negedge clk);
      cs = 1'b0;
      di = 1'b0;
      send_cmd(2'b01, 6'd10, 1'b1, 16'h0000, 0);
      finish_cs(1'b0, "R10 ignored cmd no busy");
      rd(6'd10, 0, q);
      check(q == 16'hBEEF, "R10 busy start ignored", q, 16'hBEEF);

      // R12: bits after a finished frame are ignored
      model[11] = '1;
      send_cmd(2'b11, 6'd11, 1'b0, '0, 0);
      send_cmd(2'b01, 6'd12, 1'b1, 16'h0F0F, 0);
      finish_cs(1'b1, "R12 busy from erase");
      rd(6'd11, 0, q);
      check(q == 16'hFFFF, "R12 erase done", q, 16'hFFFF);
      rd(6'd12, 0, q);
      check(q == model[12], "R12 trailing write ignored", q, model[12]);

      // R8: write-all with filler bits
      send_cmd(2'b00, {2'b01, 4'b0110}, 1'b1, 16'h5A3C, 1);
      finish_cs(1'b1, "R8 write-all busy");
      for (int a = 0; a < DEPTH; a++) model[a] = 16'h5A3C;
      read_all("R8 write-all sweep");

      // R7: erase-all
      send_cmd(2'b00, {2'b10, 4'b1001}, 1'b0, '0, 0);
      finish_cs(1'b1, "R7 erase-all busy");
      for (int a = 0; a < DEPTH; a++) model[a] = '1;
      read_all("R7 erase-all sweep");

      // R11/R5: disable, then every programming command is blocked
      send_cmd(2'b00, {2'b00, 4'b0101}, 1'b0, '0, 0);
      finish_cs(1'b0, "R11 disable no busy");
      send_cmd(2'b01, 6'd1, 1'b1, 16'h0000, 0);
      finish_cs(1'b0, "R5 write after disable no busy");
      send_cmd(2'b00, {2'b01, 4'b1111}, 1'b1, 16'h0000, 0);
      finish_cs(1'b0, "R5 write-all after disable no busy");
      read_all("R5 disabled sweep");

      // R9: oe drops with cs
      check(doe == 1'b0, "R9 oe low after cs", doe, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule